// File: doc/BRIEF.md
# Vector Multiply-Accumulate Latency Scoreboard with Deferred Flag Commit

This block follows results of the vector multiply-accumulate pipe while they are in flight. A small in-order ring holds one entry per issued instruction pair. Each entry records the destination register and component mask of the upper slot, the same for the lower slot, which flags the pair writes, a snapshot of the MAC, status and clip flags, and the cycle on which it issued. A free-running cycle counter measures every entry's age against a fixed latency.

Two source ports, each a register number with a component mask, are checked against every entry that is still young. A match on either destination tag with an overlapping mask raises a stall request. When the oldest entry reaches its latency, its snapshot is committed to the architectural flag registers. The status merge depends on whether the entry was a status-set instruction. A drain input forces the queue to empty in order, one entry per cycle, without waiting for latency. An allocating issue while the ring is full is dropped and reported.

Top module: `fmac_scoreboard`

## Requirements
- R1: While `rst` is high on a clock edge, the ring empties and `mac_flags`, `status_flags`, `clip_flags` and `overflow` become zero. With an empty ring, `stall` is low.
- R2: An `issue` allocates one entry only when `up_use` or `lo_use` is high. An issue with both low leaves the flags and `stall` unaffected.
- R3: `stall` is high in the three cycles following the issue edge of an entry when a source register equals the entry's upper tag or lower tag and the component masks overlap (bit 0 = x … bit 3 = w). A source register number of 0 never stalls, and disjoint masks do not stall.
- R4: From the fourth cycle after its issue edge, an entry no longer causes a stall.
- R5: An entry issued on edge k commits on edge k+4. Commit always loads `mac_flags` from the snapshot, and the flags do not change on any other edge.
- R6: Entries commit in issue order, at most one per edge, so back-to-back issues commit on consecutive edges.
- R7: An entry whose `flag_wr[0]` is 0 sets status to (old & 0xFF0) | (snap & 0x00F), with snapshot bits 3:0 also ORed into bits 9:6. Bits 9:6 therefore never clear on such a commit.
- R8: An entry whose `flag_wr[0]` is 1 sets status to (old & 0x030) | (snap & 0xFC0) | (snap & 0x00F).
- R9: `clip_flags` is loaded from the snapshot on commit only when `flag_wr[1]` is 1. Otherwise it holds its value.
- R10: An allocating issue on an edge where the ring holds 4 entries is dropped. It never commits or stalls, and `overflow` is high for exactly the cycle after that edge.
- R11: While `drain` is high and the ring is not empty, the oldest entry commits on every edge regardless of its age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction pair issues this cycle |
| up_use | input | 1 | Upper slot uses the multiply-accumulate pipe |
| up_dst | input | 5 | Upper slot destination register |
| up_mask | input | 4 | Upper slot destination components |
| lo_use | input | 1 | Lower slot uses the multiply-accumulate pipe |
| lo_dst | input | 5 | Lower slot destination register |
| lo_mask | input | 4 | Lower slot destination components |
| flag_wr | input | 2 | Bit 0 status-set, bit 1 clip write |
| mac_snap | input | 16 | MAC flag snapshot |
| stat_snap | input | 12 | Status flag snapshot |
| clip_snap | input | 24 | Clip flag snapshot |
| rd0_reg | input | 5 | Source port 0 register |
| rd0_mask | input | 4 | Source port 0 components |
| rd1_reg | input | 5 | Source port 1 register |
| rd1_mask | input | 4 | Source port 1 components |
| drain | input | 1 | Commit the oldest entry every edge, ignoring age |
| stall | output | 1 | Read-after-write hazard on a source port |
| mac_flags | output | 16 | Architectural MAC flags |
| status_flags | output | 12 | Architectural status flags |
| clip_flags | output | 24 | Architectural clip flags |
| overflow | output | 1 | Previous edge dropped an issue into a full ring |

## Verification
Flag results are due on the fourth edge after the issue edge, or earlier under drain. The driver stamps every expected commit with that edge number. The monitor compares the three flag outputs at the falling edge right after exactly that edge, and reports any item whose edge passed unseen. `stall` is combinational, so it is sampled one step after the source ports are driven in the falling-edge half of each of the cycles 1 to 4 after issue. `overflow` is sampled in the single cycle after the dropped edge and again one cycle later.

// File: rtl/fmac_sb_pkg.sv
`timescale 1ns/1ps
package fmac_sb_pkg;
  parameter int REG_W  = 5;
  parameter int CMP_W  = 4;
  parameter int FW_W   = 2;
  parameter int MAC_W  = 16;
  parameter int STAT_W = 12;
  parameter int CLIP_W = 24;
  parameter int TIME_W = 8;

  localparam int FW_STATUS = 0;
  localparam int FW_CLIP   = 1;
  localparam int STICKY_SH = 6;

  localparam logic [STAT_W-1:0] ST_KEEP_SET  = STAT_W'('h030);
  localparam logic [STAT_W-1:0] ST_SNAP_SET  = STAT_W'('hFC0);
  localparam logic [STAT_W-1:0] ST_LIVE      = STAT_W'('h00F);
  localparam logic [STAT_W-1:0] ST_KEEP_NORM = STAT_W'('hFF0);
  localparam logic [STAT_W-1:0] ST_STICKY    = STAT_W'('h3C0);

  // hazard-relevant part of an entry
  typedef struct packed {
    logic [REG_W-1:0]  up_tag;
    logic [CMP_W-1:0]  up_msk;
    logic [REG_W-1:0]  lo_tag;
    logic [CMP_W-1:0]  lo_msk;
    logic [TIME_W-1:0] stamp;
  } tag_t;

  // commit-relevant part of an entry
  typedef struct packed {
    logic [FW_W-1:0]   fw;
    logic [MAC_W-1:0]  mac;
    logic [STAT_W-1:0] stat;
    logic [CLIP_W-1:0] clip;
  } flag_t;

  function automatic logic src_hits(tag_t t, logic [REG_W-1:0] r, logic [CMP_W-1:0] m);
    return (r != '0) &&
           (((t.up_tag == r) && (|(t.up_msk & m))) ||
            ((t.lo_tag == r) && (|(t.lo_msk & m))));
  endfunction
endpackage

// File: rtl/fmac_sb_ring.sv
`timescale 1ns/1ps
module fmac_sb_ring
  import fmac_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push,
  input  tag_t                 push_tag,
  input  flag_t                push_flag,
  input  logic                 pop,
  output tag_t  [DEPTH-1:0]    tags,
  output flag_t                head_flag,
  output logic  [PTR_W-1:0]    rd_ptr,
  output logic  [CNT_W-1:0]    count
);
  logic [PTR_W-1:0] wr_ptr;
  tag_t             tag_mem  [DEPTH];
  flag_t            flag_mem [DEPTH];

  // snapshot storage: single write port, one read address
  always_ff @(posedge clk) begin
    if (push) begin
      tag_mem[wr_ptr]  <= push_tag;
      flag_mem[wr_ptr] <= push_flag;
    end
  end

  assign head_flag = flag_mem[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tags
    assign tags[i] = tag_mem[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/fmac_sb_hazard.sv
`timescale 1ns/1ps
module fmac_sb_hazard
  import fmac_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LAT   = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  tag_t [DEPTH-1:0]  tags,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [CNT_W-1:0]  count,
  input  logic [TIME_W-1:0] now,
  input  logic [REG_W-1:0]  rd0_reg,
  input  logic [CMP_W-1:0]  rd0_mask,
  input  logic [REG_W-1:0]  rd1_reg,
  input  logic [CMP_W-1:0]  rd1_mask,
  output logic              stall
);
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [PTR_W-1:0]  offset;
    logic [TIME_W-1:0] age;
    logic              live, young;
    assign offset = PTR_W'(i) - rd_ptr;
    assign live   = CNT_W'(offset) < count;
    assign age    = now - tags[i].stamp;
    assign young  = age < TIME_W'(LAT);
    assign hit[i] = live && young &&
                    (src_hits(tags[i], rd0_reg, rd0_mask) ||
                     src_hits(tags[i], rd1_reg, rd1_mask));
  end

  assign stall = |hit;
endmodule

// File: rtl/fmac_sb_commit.sv
`timescale 1ns/1ps
module fmac_sb_commit
  import fmac_sb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pop,
  input  flag_t             head,
  output logic [MAC_W-1:0]  mac_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [CLIP_W-1:0] clip_q
);
  logic [STAT_W-1:0] stat_next;

  always_comb begin
    if (head.fw[FW_STATUS])
      stat_next = (stat_q & ST_KEEP_SET) | (head.stat & ST_SNAP_SET) | (head.stat & ST_LIVE);
    else
      stat_next = (stat_q & ST_KEEP_NORM) | (head.stat & ST_LIVE) |
                  ((head.stat & ST_LIVE) << STICKY_SH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_q  <= '0;
      stat_q <= '0;
      clip_q <= '0;
    end else if (pop) begin
      mac_q  <= head.mac;
      stat_q <= stat_next;
      if (head.fw[FW_CLIP]) clip_q <= head.clip;
    end
  end
endmodule

// File: rtl/fmac_scoreboard.sv
`timescale 1ns/1ps
module fmac_scoreboard
  import fmac_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LAT   = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              up_use,
  input  logic [REG_W-1:0]  up_dst,
  input  logic [CMP_W-1:0]  up_mask,
  input  logic              lo_use,
  input  logic [REG_W-1:0]  lo_dst,
  input  logic [CMP_W-1:0]  lo_mask,
  input  logic [FW_W-1:0]   flag_wr,
  input  logic [MAC_W-1:0]  mac_snap,
  input  logic [STAT_W-1:0] stat_snap,
  input  logic [CLIP_W-1:0] clip_snap,
  input  logic [REG_W-1:0]  rd0_reg,
  input  logic [CMP_W-1:0]  rd0_mask,
  input  logic [REG_W-1:0]  rd1_reg,
  input  logic [CMP_W-1:0]  rd1_mask,
  input  logic              drain,
  output logic              stall,
  output logic [MAC_W-1:0]  mac_flags,
  output logic [STAT_W-1:0] status_flags,
  output logic [CLIP_W-1:0] clip_flags,
  output logic              overflow
);
  logic [TIME_W-1:0] now;
  logic              alloc, push, pop;
  tag_t              push_tag;
  flag_t             push_flag;
  tag_t [DEPTH-1:0]  tags;
  flag_t             head_flag;
  logic [PTR_W-1:0]  rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [TIME_W-1:0] head_age;
  logic [FW_W-1:0]   head_fw;

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + TIME_W'(1);
  end

  assign alloc = issue && (up_use || lo_use);
  assign push  = alloc && (count != CNT_W'(DEPTH));

  always_comb begin
    push_tag.up_tag = up_use ? up_dst  : '0;
    push_tag.up_msk = up_use ? up_mask : '0;
    push_tag.lo_tag = lo_use ? lo_dst  : '0;
    push_tag.lo_msk = lo_use ? lo_mask : '0;
    push_tag.stamp  = now;
    push_flag.fw    = flag_wr;
    push_flag.mac   = mac_snap;
    push_flag.stat  = stat_snap;
    push_flag.clip  = clip_snap;
  end

  assign head_age = now - tags[rd_ptr].stamp;
  assign pop      = (count != '0) && (drain || (head_age >= TIME_W'(LAT)));
  assign head_fw  = head_flag.fw;

  always_ff @(posedge clk) begin
    if (rst) overflow <= 1'b0;
    else     overflow <= alloc && (count == CNT_W'(DEPTH));
  end

  fmac_sb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .push(push), .push_tag(push_tag), .push_flag(push_flag),
    .pop(pop), .tags(tags), .head_flag(head_flag), .rd_ptr(rd_ptr), .count(count)
  );

  fmac_sb_hazard #(.DEPTH(DEPTH), .LAT(LAT)) u_hazard (
    .tags(tags), .rd_ptr(rd_ptr), .count(count), .now(now),
    .rd0_reg(rd0_reg), .rd0_mask(rd0_mask), .rd1_reg(rd1_reg), .rd1_mask(rd1_mask),
    .stall(stall)
  );

  fmac_sb_commit u_commit (
    .clk(clk), .rst(rst), .pop(pop), .head(head_flag),
    .mac_q(mac_flags), .stat_q(status_flags), .clip_q(clip_flags)
  );
endmodule

// File: rtl/fmac_scoreboard_chk.sv
`timescale 1ns/1ps
module fmac_scoreboard_chk
  import fmac_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              issue,
  input logic              up_use,
  input logic              lo_use,
  input logic              drain,
  input logic              stall,
  input logic              pop,
  input logic [CNT_W-1:0]  count,
  input logic [FW_W-1:0]   head_fw,
  input logic [MAC_W-1:0]  mac_flags,
  input logic [STAT_W-1:0] status_flags,
  input logic [CLIP_W-1:0] clip_flags,
  input logic              overflow
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0 && mac_flags == '0 && status_flags == '0 && clip_flags == '0 && !overflow));

  a_r1_empty_no_stall: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !stall);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !pop |=> ($stable(mac_flags) && $stable(status_flags) && $stable(clip_flags)));

  a_r7_sticky_kept: assert property (@(posedge clk) disable iff (rst)
    (pop && !head_fw[FW_STATUS]) |=>
      ((status_flags & $past(status_flags) & ST_STICKY) == ($past(status_flags) & ST_STICKY)));

  a_r9_clip_hold: assert property (@(posedge clk) disable iff (rst)
    (pop && !head_fw[FW_CLIP]) |=> $stable(clip_flags));

  a_r10_overflow: assert property (@(posedge clk) disable iff (rst)
    (issue && (up_use || lo_use) && count == CNT_W'(DEPTH)) |=> overflow);

  a_r11_drain_pops: assert property (@(posedge clk) disable iff (rst)
    (drain && count != '0) |-> pop);
endmodule

bind fmac_scoreboard fmac_scoreboard_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .up_use(up_use), .lo_use(lo_use),
  .drain(drain), .stall(stall), .pop(pop), .count(count), .head_fw(head_fw),
  .mac_flags(mac_flags), .status_flags(status_flags), .clip_flags(clip_flags),
  .overflow(overflow)
);

// File: tb/fmac_scoreboard_test.sv
`timescale 1ns/1ps
module fmac_scoreboard_test;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst, issue, up_use, lo_use, drain;
  logic [4:0] up_dst, lo_dst, rd0_reg, rd1_reg;
  logic [3:0] up_mask, lo_mask, rd0_mask, rd1_mask;
  logic [1:0] flag_wr;
  logic [15:0] mac_snap, mac_flags;
  logic [11:0] stat_snap, status_flags;
  logic [23:0] clip_snap, clip_flags;
  logic stall, overflow;

  fmac_scoreboard uut (.*);

  int edges = 0;
  always @(posedge clk) edges <= edges + 1;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic [15:0] mac;
    logic [11:0] st;
    logic [23:0] cl;
    string       req;
  } exp_t;
  exp_t q[$];
  logic [11:0] m_st = '0;
  logic [23:0] m_cl = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] merge(input logic [11:0] old, input logic [11:0] snap, input bit set);
    if (set) return (old & 12'h030) | (snap & 12'hFC0) | (snap & 12'h00F);
    return (old & 12'hFF0) | (snap & 12'h00F) | {2'b00, snap[3:0], 6'b000000};
  endfunction

  // driver: called at a falling edge, issues on the next rising edge
  task automatic issue_op(input bit uu, input logic [4:0] ud, input logic [3:0] um,
                          input bit lu, input logic [4:0] ld, input logic [3:0] lm,
                          input logic [1:0] fw, input logic [15:0] mac,
                          input logic [11:0] st, input logic [23:0] cl,
                          input string req, input int due_ovr, input bit alloc);
    exp_t e;
    issue = 1; up_use = uu; up_dst = ud; up_mask = um;
    lo_use = lu; lo_dst = ld; lo_mask = lm; flag_wr = fw;
    mac_snap = mac; stat_snap = st; clip_snap = cl;
    if (alloc) begin
      m_st = merge(m_st, st, fw[0]);
      if (fw[1]) m_cl = cl;
      e.due = (due_ovr >= 0) ? due_ovr : edges + 5;
      e.mac = mac; e.st = m_st; e.cl = m_cl; e.req = req;
      q.push_back(e);
    end
    @(negedge clk);
    issue = 0; up_use = 0; lo_use = 0;
  endtask

  task automatic stall_chk(input logic [4:0] r0, input logic [3:0] m0,
                           input logic [4:0] r1, input logic [3:0] m1,
                           input bit exp, input string req);
    rd0_reg = r0; rd0_mask = m0; rd1_reg = r1; rd1_mask = m1;
    #1;
    chk(stall == exp, req, "stall", stall, exp);
    rd0_reg = 0; rd0_mask = 0; rd1_reg = 0; rd1_mask = 0;
  endtask

  // monitor: compares each expected commit right after its due edge
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].due < edges) begin
        chk(0, q[0].req, "commit missed at edge", edges, q[0].due);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].due == edges) begin
        chk(mac_flags == q[0].mac, q[0].req, "mac_flags", mac_flags, q[0].mac);
        chk(status_flags == q[0].st, q[0].req, "status_flags", status_flags, q[0].st);
        chk(clip_flags == q[0].cl, q[0].req, "clip_flags", clip_flags, q[0].cl);
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    int e0;
    rst = 1; issue = 0; up_use = 0; lo_use = 0; drain = 0;
    up_dst = 0; lo_dst = 0; up_mask = 0; lo_mask = 0; flag_wr = 0;
    mac_snap = 0; stat_snap = 0; clip_snap = 0;
    rd0_reg = 0; rd0_mask = 0; rd1_reg = 0; rd1_mask = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(mac_flags == 0, "R1", "mac_flags", mac_flags, 0);
    chk(status_flags == 0, "R1", "status_flags", status_flags, 0);
    chk(clip_flags == 0, "R1", "clip_flags", clip_flags, 0);
    chk(overflow == 0, "R1", "overflow", overflow, 0);
    stall_chk(5, 4'hF, 5, 4'hF, 0, "R1");

    // R3 R4 R5 R7: upper slot, x component, plain status
    issue_op(1, 3, 4'b0001, 0, 0, 0, 2'b00, 16'h1234, 12'h005, 24'h00ABCD, "R5", -1, 1);
    stall_chk(3, 4'b0001, 0, 0, 1, "R3");
    stall_chk(3, 4'b0010, 0, 0, 0, "R3");
    stall_chk(0, 0, 3, 4'b1111, 1, "R3");
    @(negedge clk);
    stall_chk(3, 4'b0001, 0, 0, 1, "R3");
    @(negedge clk);
    stall_chk(3, 4'b0001, 0, 0, 1, "R3");
    @(negedge clk);
    stall_chk(3, 4'b0001, 0, 0, 0, "R4");
    chk(mac_flags == 0, "R5", "mac_flags early", mac_flags, 0);
    repeat (3) @(negedge clk);

    // R3 lower slot tag, register 0 never stalls, R7 sticky
    issue_op(1, 0, 4'hF, 1, 7, 4'b1000, 2'b00, 16'h2222, 12'h00A, 24'h000001, "R7", -1, 1);
    stall_chk(7, 4'b0100, 0, 0, 0, "R3");
    stall_chk(0, 0, 7, 4'b1100, 1, "R3");
    stall_chk(0, 4'hF, 0, 0, 0, "R3");
    repeat (5) @(negedge clk);

    // R8 status-set and R9 clip write
    issue_op(1, 9, 4'hF, 0, 0, 0, 2'b11, 16'h3333, 12'hA85, 24'h55AA33, "R8", -1, 1);
    repeat (5) @(negedge clk);
    issue_op(1, 9, 4'hF, 0, 0, 0, 2'b00, 16'h4444, 12'h000, 24'h111111, "R9", -1, 1);
    repeat (5) @(negedge clk);
    chk(clip_flags == 24'h55AA33, "R9", "clip held", clip_flags, 24'h55AA33);
    chk(status_flags == 12'hA80, "R7", "sticky kept", status_flags, 12'hA80);

    // R6 back-to-back commits, R10 overflow on the fifth
    issue_op(1, 1, 4'h1, 0, 0, 0, 2'b00, 16'h5001, 12'h001, 24'h0, "R6", -1, 1);
    issue_op(1, 2, 4'h2, 0, 0, 0, 2'b00, 16'h5002, 12'h002, 24'h0, "R6", -1, 1);
    issue_op(0, 0, 4'h0, 1, 4, 4'h4, 2'b00, 16'h5003, 12'h004, 24'h0, "R6", -1, 1);
    issue_op(1, 6, 4'h8, 1, 8, 4'h1, 2'b00, 16'h5004, 12'h008, 24'h0, "R6", -1, 1);
    issue_op(1, 20, 4'hF, 0, 0, 0, 2'b10, 16'hFFFF, 12'hFFF, 24'hFFFFFF, "R10", -1, 0);
    chk(overflow == 1, "R10", "overflow", overflow, 1);
    stall_chk(20, 4'hF, 0, 0, 0, "R10");
    @(negedge clk);
    chk(overflow == 0, "R10", "overflow pulse", overflow, 0);
    repeat (6) @(negedge clk);
    chk(mac_flags == 16'h5004, "R10", "dropped never commits", mac_flags, 16'h5004);
    chk(clip_flags == 24'h55AA33, "R10", "dropped clip", clip_flags, 24'h55AA33);

    // R2 non-allocating issue
    issue_op(0, 12, 4'hF, 0, 12, 4'hF, 2'b11, 16'hBEEF, 12'hFFF, 24'h123456, "R2", -1, 0);
    stall_chk(12, 4'hF, 0, 0, 0, "R2");
    repeat (6) @(negedge clk);
    chk(mac_flags == 16'h5004, "R2", "mac unchanged", mac_flags, 16'h5004);
    chk(status_flags == m_st, "R2", "status unchanged", status_flags, m_st);

    // R11 drain commits early, in order
    e0 = edges;
    issue_op(1, 10, 4'hF, 0, 0, 0, 2'b00, 16'h6001, 12'h003, 24'h0, "R11", e0 + 4, 1);
    issue_op(1, 11, 4'hF, 0, 0, 0, 2'b10, 16'h6002, 12'h005, 24'h0C0C0C, "R11", e0 + 5, 1);
    issue_op(1, 13, 4'hF, 0, 0, 0, 2'b01, 16'h6003, 12'h9C6, 24'h0, "R11", e0 + 6, 1);
    drain = 1;
    repeat (3) @(negedge clk);
    drain = 0;
    stall_chk(13, 4'hF, 0, 0, 0, "R11");
    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R6", "pending expectations", q.size(), 0);

    done = 1;
    finish_run();
  end
endmodule